// File: doc/BRIEF.md
# UART Receive Interrupt and DMA Request Controller

This block sits beside a UART receive FIFO and turns its occupancy, strobes and line flags into interrupt sources and four-byte DMA burst requests. A host sees one interrupt line. It finds the source by reading an identification byte that reports the single most urgent pending cause. An enable byte masks the sources. A FIFO control write selects DMA mode or clears the receive FIFO. A line status byte reports data-ready and sticky error flags.

Two idle-gap timers cover the bytes that DMA bursts leave behind. Both count 16x baud ticks since the last received byte, and one character time is 16 ticks times the frame length in bits. After three character times of silence, a residue smaller than one burst raises a receive timeout. After four character times, an end-of-receive-data event is latched. The timeout is always visible first. The end-of-receive-data event stays latched until software writes its enable bit to 0 and then back to 1. Reading data does not clear it.

Top module: `uart_rx_irq_ctrl`

## Requirements
- R1: After synchronous reset, `irq` and `dma_req` are 0, the identification byte (address 1) reads 0x01 and the line status byte (address 2) reads 0x00 with an empty FIFO.
- R2: The identification byte has bit 0 set to 1 when nothing is pending. Otherwise bit 0 is 0 and bits 3:1 carry the source code: 0 modem change, 1 transmit level, 2 receive data, 3 line error, 4 end of receive data, 6 receive timeout. Codes 5 and 7 never appear. `irq` is 1 exactly when a source is pending.
- R3: When several sources are pending, the code reported follows this order, highest first: line error, receive timeout, end of receive data, receive data, transmit level, modem change.
- R4: The receive data source (enable bit 0 at address 0) is pending when DMA mode is off and `rx_count` is greater than 4.
- R5: The transmit level source (enable bit 1) is pending when `tx_count` is at most 4 in DMA mode, or at most 8 otherwise.
- R6: The end-of-receive-data event latches when 64 × `frame_bits` baud ticks pass with no received byte. Each byte restarts the count. The count runs only after at least one byte has arrived since the event last fired or the FIFO was cleared. The event is reported when enable bit 5 is set.
- R7: The latched end-of-receive-data event clears only on a write to address 0 that sets bit 5 while bit 5 was 0. Rewriting bit 5 as 1 when it is already 1 has no effect.
- R8: The receive timeout (enable bit 4) latches after 48 × `frame_bits` idle ticks. It is pending while `rx_count` is 1 to 3 in DMA mode, or 1 to 4 otherwise. It precedes end of receive data for the same gap, and a new byte cancels it.
- R9: Line status bits are: bit 0 data ready (`rx_count` ≠ 0), bit 1 overrun, bit 2 parity, bit 3 framing, bit 4 break, bit 7 FIFO error (parity, framing or break). The error bits are sticky, feed the line error source (enable bit 2), and clear on a read of address 2. An error strobe that arrives on the same cycle as the read wins.
- R10: A modem change strobe sets a flag, read at bit 0 of address 3. The flag feeds the modem source (enable bit 3) and clears on that read. A strobe on the same cycle wins.
- R11: Writing address 1 with bit 3 set selects DMA mode. In DMA mode `dma_req` rises once `rx_count` is at least 4. It stays high through four `rx_pop` strobes and falls after the fourth.
- R12: A write to address 1 with bit 1 set drives `rx_clr` high in that same cycle. It also stops the idle timer, drops a latched timeout and cancels a burst in progress.
- R13: In DMA mode the receive data source is never reported, whatever `rx_count` and enable bit 0 hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_push | input | 1 | One byte entered the receive FIFO |
| rx_pop | input | 1 | One byte was read from the receive FIFO |
| err_overrun | input | 1 | Overrun strobe |
| err_parity | input | 1 | Parity error strobe |
| err_frame | input | 1 | Framing error strobe |
| err_break | input | 1 | Break strobe |
| modem_delta | input | 1 | Modem line change strobe |
| tx_count | input | CNT_W | Transmit FIFO occupancy |
| baud_tick | input | 1 | 16x baud tick |
| frame_bits | input | FRAME_W | Character length in bits including start, parity and stop |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clear-on-read side effects) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt line |
| dma_req | output | 1 | Four-byte DMA burst request |
| rx_clr | output | 1 | Receive FIFO clear pulse |

## Verification
The delicate overlap is a receive timeout and an end-of-receive-data event that are both pending at the same time. The bench leaves two bytes behind a DMA burst and waits through the idle gap. The timeout code must appear first and must keep precedence once the end-of-receive-data event also latches. Draining the residue must then expose the end-of-receive-data code, and only the enable toggle may retire it. A second collision is tested by pulsing an error strobe and a modem strobe in the very cycle of the clearing read, and the flag must survive. A reference model updated on every edge judges `irq`, `dma_req`, `rx_clr` and every read value on every cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    // register addresses
    localparam logic [1:0] A_ENABLE = 2'd0;
    localparam logic [1:0] A_IDENT  = 2'd1;   // read: identification, write: FIFO control
    localparam logic [1:0] A_LSTAT  = 2'd2;
    localparam logic [1:0] A_MSTAT  = 2'd3;

    // enable bit positions
    localparam int EN_RXD  = 0;
    localparam int EN_TXL  = 1;
    localparam int EN_LINE = 2;
    localparam int EN_MOD  = 3;
    localparam int EN_TMO  = 4;
    localparam int EN_EORD = 5;

    // FIFO control bit positions
    localparam int FC_RXCLR = 1;
    localparam int FC_DMA   = 3;

    typedef enum logic [2:0] {
        SRC_MODEM = 3'd0,
        SRC_TXLVL = 3'd1,
        SRC_RXDAT = 3'd2,
        SRC_LINE  = 3'd3,
        SRC_EORD  = 3'd4,
        SRC_TMO   = 3'd6
    } src_e;

    typedef struct packed {
        logic line;
        logic tmo;
        logic eord;
        logic rxd;
        logic txl;
        logic modem;
    } pend_t;

    typedef struct packed {
        logic ovr;
        logic par;
        logic frm;
        logic brk;
    } lerr_t;

    function automatic logic [7:0] ident_byte(input logic none, input src_e s);
        return {4'b0000, s, none};
    endfunction

    function automatic logic [7:0] lstat_byte(input logic ready, input lerr_t e);
        return {(e.par | e.frm | e.brk), 2'b00, e.brk, e.frm, e.par, e.ovr, ready};
    endfunction

endpackage

// File: rtl/uirq_idle_timer.sv
module uirq_idle_timer
    import uirq_pkg::*;
#(
    parameter int FRAME_W    = 4,
    parameter int TMO_CHARS  = 3,
    parameter int EORD_CHARS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic               baud_tick,
    input  logic               rx_push,
    input  logic               flush,
    input  logic               eord_clr,
    output logic               tmo_flag,
    output logic               eord_flag
);
    localparam int TW = FRAME_W + 4 + $clog2(EORD_CHARS + 1);

    logic [TW-1:0] idle_q, idle_nx, char_ticks, tmo_lim, eord_lim;
    logic          armed_q, tmo_q, eord_q, eord_hit;

    assign char_ticks = TW'({frame_bits, 4'b0000});
    assign tmo_lim    = TW'(char_ticks * TW'(TMO_CHARS));
    assign eord_lim   = TW'(char_ticks * TW'(EORD_CHARS));
    assign idle_nx    = idle_q + TW'(1);
    assign eord_hit   = !flush && !rx_push && armed_q && baud_tick && (idle_nx == eord_lim);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle_q  <= '0;
            armed_q <= 1'b0;
            tmo_q   <= 1'b0;
        end else if (flush) begin
            idle_q  <= '0;
            armed_q <= 1'b0;
            tmo_q   <= 1'b0;
        end else if (rx_push) begin
            idle_q  <= '0;
            armed_q <= 1'b1;
            tmo_q   <= 1'b0;
        end else if (armed_q && baud_tick) begin
            if (idle_nx == tmo_lim) tmo_q <= 1'b1;
            if (eord_hit) begin
                idle_q  <= '0;
                armed_q <= 1'b0;
            end else begin
                idle_q  <= idle_nx;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           eord_q <= 1'b0;
        else if (eord_hit) eord_q <= 1'b1;
        else if (eord_clr) eord_q <= 1'b0;
    end

    assign tmo_flag  = tmo_q;
    assign eord_flag = eord_q;

    // R6
    eord_armed_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(eord_q) |-> $past(armed_q));
    // R7
    eord_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(eord_q) |-> $past(eord_clr));
    // R8
    tmo_cancel_chk: assert property (@(posedge clk) disable iff (rst)
        (tmo_q && rx_push) |=> !tmo_q);
endmodule

// File: rtl/uirq_dma_burst.sv
module uirq_dma_burst
    import uirq_pkg::*;
#(
    parameter int CNT_W = 6,
    parameter int BURST = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dma_mode,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_pop,
    input  logic             flush,
    output logic             dma_req
);
    localparam int PW = $clog2(BURST) + 1;

    logic          act_q;
    logic [PW-1:0] pops_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            act_q  <= 1'b0;
            pops_q <= '0;
        end else if (act_q) begin
            if (rx_pop) begin
                if (pops_q == PW'(BURST - 1)) begin
                    act_q  <= 1'b0;
                    pops_q <= '0;
                end else begin
                    pops_q <= pops_q + PW'(1);
                end
            end
        end else if (dma_mode && (rx_count >= CNT_W'(BURST))) begin
            act_q <= 1'b1;
        end
    end

    assign dma_req = act_q & dma_mode;

    // R11
    burst_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(act_q) |-> $past(rx_count >= CNT_W'(BURST)));
    // R11
    burst_len_chk: assert property (@(posedge clk) disable iff (rst)
        pops_q < PW'(BURST));
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
    import uirq_pkg::*;
(
    input  pend_t      pend,
    output logic [7:0] ident
);
    always_comb begin
        if (pend.line)       ident = ident_byte(1'b0, SRC_LINE);
        else if (pend.tmo)   ident = ident_byte(1'b0, SRC_TMO);
        else if (pend.eord)  ident = ident_byte(1'b0, SRC_EORD);
        else if (pend.rxd)   ident = ident_byte(1'b0, SRC_RXDAT);
        else if (pend.txl)   ident = ident_byte(1'b0, SRC_TXLVL);
        else if (pend.modem) ident = ident_byte(1'b0, SRC_MODEM);
        else                 ident = ident_byte(1'b1, SRC_MODEM);
    end
endmodule

// File: rtl/uart_rx_irq_ctrl.sv
module uart_rx_irq_ctrl
    import uirq_pkg::*;
#(
    parameter int CNT_W       = 6,
    parameter int FRAME_W     = 4,
    parameter int RX_TRIG     = 4,
    parameter int TX_TRIG_DMA = 4,
    parameter int TX_TRIG_PIO = 8,
    parameter int BURST       = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [CNT_W-1:0]   rx_count,
    input  logic               rx_push,
    input  logic               rx_pop,
    input  logic               err_overrun,
    input  logic               err_parity,
    input  logic               err_frame,
    input  logic               err_break,
    input  logic               modem_delta,
    input  logic [CNT_W-1:0]   tx_count,
    input  logic               baud_tick,
    input  logic [FRAME_W-1:0] frame_bits,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [1:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               irq,
    output logic               dma_req,
    output logic               rx_clr
);
    logic [5:0] en_q;
    logic       dma_mode_q, modem_q;
    lerr_t      lerr_q;
    logic       wr_en, wr_fc, rd_ls, rd_ms, flush, eord_clr;
    logic       tmo_flag, eord_flag, residue;
    pend_t      pend;
    logic [7:0] ident;

    assign wr_en    = reg_wr && (reg_addr == A_ENABLE);
    assign wr_fc    = reg_wr && (reg_addr == A_IDENT);
    assign rd_ls    = reg_rd && (reg_addr == A_LSTAT);
    assign rd_ms    = reg_rd && (reg_addr == A_MSTAT);
    assign flush    = wr_fc && reg_wdata[FC_RXCLR];
    assign eord_clr = wr_en && reg_wdata[EN_EORD] && !en_q[EN_EORD];
    assign rx_clr   = flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q       <= '0;
            dma_mode_q <= 1'b0;
        end else begin
            if (wr_en) en_q       <= reg_wdata[5:0];
            if (wr_fc) dma_mode_q <= reg_wdata[FC_DMA];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lerr_q  <= '0;
            modem_q <= 1'b0;
        end else begin
            lerr_q.ovr <= err_overrun | (lerr_q.ovr & !rd_ls);
            lerr_q.par <= err_parity  | (lerr_q.par & !rd_ls);
            lerr_q.frm <= err_frame   | (lerr_q.frm & !rd_ls);
            lerr_q.brk <= err_break   | (lerr_q.brk & !rd_ls);
            modem_q    <= modem_delta | (modem_q & !rd_ms);
        end
    end

    uirq_idle_timer #(.FRAME_W(FRAME_W)) u_idle (
        .clk(clk), .rst(rst), .frame_bits(frame_bits), .baud_tick(baud_tick),
        .rx_push(rx_push), .flush(flush), .eord_clr(eord_clr),
        .tmo_flag(tmo_flag), .eord_flag(eord_flag)
    );

    uirq_dma_burst #(.CNT_W(CNT_W), .BURST(BURST)) u_burst (
        .clk(clk), .rst(rst), .dma_mode(dma_mode_q), .rx_count(rx_count),
        .rx_pop(rx_pop), .flush(flush), .dma_req(dma_req)
    );

    assign residue = (rx_count != '0) &&
                     (dma_mode_q ? (rx_count < CNT_W'(BURST)) : (rx_count <= CNT_W'(RX_TRIG)));

    always_comb begin
        pend.line  = en_q[EN_LINE] && (|lerr_q);
        pend.tmo   = en_q[EN_TMO]  && tmo_flag && residue;
        pend.eord  = en_q[EN_EORD] && eord_flag;
        pend.rxd   = en_q[EN_RXD]  && !dma_mode_q && (rx_count > CNT_W'(RX_TRIG));
        pend.txl   = en_q[EN_TXL]  &&
                     (tx_count <= (dma_mode_q ? CNT_W'(TX_TRIG_DMA) : CNT_W'(TX_TRIG_PIO)));
        pend.modem = en_q[EN_MOD]  && modem_q;
    end

    uirq_prio u_prio (.pend(pend), .ident(ident));

    assign irq = |pend;

    always_comb begin
        case (reg_addr)
            A_ENABLE: reg_rdata = {2'b00, en_q};
            A_IDENT:  reg_rdata = ident;
            A_LSTAT:  reg_rdata = lstat_byte(rx_count != '0, lerr_q);
            default:  reg_rdata = {7'b0, modem_q};
        endcase
    end

    // R2
    irq_ident_chk: assert property (@(posedge clk) disable iff (rst)
        irq != ident[0]);
    // R2
    no_code57_chk: assert property (@(posedge clk) disable iff (rst)
        !ident[0] |-> (ident[3:1] != 3'd5 && ident[3:1] != 3'd7));
    // R3
    line_first_chk: assert property (@(posedge clk) disable iff (rst)
        pend.line |-> (ident[3:1] == 3'd3));
    // R9
    lerr_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(|lerr_q) |-> $past(rd_ls));
    // R10
    modem_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(modem_q) |-> $past(rd_ms));
    // R13
    dma_no_rxd_chk: assert property (@(posedge clk) disable iff (rst)
        dma_mode_q |-> (ident[3:1] != 3'd2 || ident[0]));
endmodule

// File: tb/uart_rx_irq_ctrl_bench.sv
module uart_rx_irq_ctrl_bench;
    localparam int CW = 6;
    localparam int FW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [CW-1:0] rx_count = '0, tx_count = 6'd16;
    logic          rx_push = 0, rx_pop = 0, err_overrun = 0, err_parity = 0;
    logic          err_frame = 0, err_break = 0, modem_delta = 0, baud_tick = 1;
    logic [FW-1:0] frame_bits = 4'd2;
    logic          reg_wr = 0, reg_rd = 0;
    logic [1:0]    reg_addr = 0;
    logic [7:0]    reg_wdata = 0;
    logic [7:0]    reg_rdata;
    logic          irq, dma_req, rx_clr;

    always #4 clk = ~clk;

    uart_rx_irq_ctrl u_uart_rx_irq_ctrl (
        .clk(clk), .rst(rst), .rx_count(rx_count), .rx_push(rx_push), .rx_pop(rx_pop),
        .err_overrun(err_overrun), .err_parity(err_parity), .err_frame(err_frame),
        .err_break(err_break), .modem_delta(modem_delta), .tx_count(tx_count),
        .baud_tick(baud_tick), .frame_bits(frame_bits), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .dma_req(dma_req), .rx_clr(rx_clr)
    );

    int    n_tests = 0, n_fail = 0, cycles = 0;
    string cur_req = "R1";

    // reference model state
    int  m_ier, m_dma, m_idle, m_armed, m_tmo, m_eord, m_mod, m_act, m_pops, m_ch;
    bit  m_ovr, m_par, m_frm, m_brk, m_hit;

    always @(posedge clk) begin
        if (rst) begin
            m_ier = 0; m_dma = 0; m_idle = 0; m_armed = 0; m_tmo = 0; m_eord = 0;
            m_mod = 0; m_act = 0; m_pops = 0;
            {m_ovr, m_par, m_frm, m_brk} = 4'b0;
        end else begin
            m_ch = 16 * frame_bits;
            if (reg_rd && reg_addr == 2) {m_ovr, m_par, m_frm, m_brk} = 4'b0;
            if (err_overrun) m_ovr = 1;
            if (err_parity)  m_par = 1;
            if (err_frame)   m_frm = 1;
            if (err_break)   m_brk = 1;
            if (reg_rd && reg_addr == 3) m_mod = 0;
            if (modem_delta) m_mod = 1;
            m_hit = 0;
            if (reg_wr && reg_addr == 1 && reg_wdata[1]) begin
                m_idle = 0; m_armed = 0; m_tmo = 0; m_act = 0; m_pops = 0;
            end else begin
                if (rx_push) begin
                    m_idle = 0; m_armed = 1; m_tmo = 0;
                end else if (m_armed != 0 && baud_tick) begin
                    m_idle++;
                    if (m_idle == 3 * m_ch) m_tmo = 1;
                    if (m_idle == 4 * m_ch) begin m_hit = 1; m_armed = 0; m_idle = 0; end
                end
                if (m_act != 0) begin
                    if (rx_pop) begin
                        m_pops++;
                        if (m_pops == 4) begin m_act = 0; m_pops = 0; end
                    end
                end else if (m_dma != 0 && rx_count >= 4) m_act = 1;
            end
            if (reg_wr && reg_addr == 0 && reg_wdata[5] && m_ier[5] == 0) m_eord = 0;
            if (m_hit) m_eord = 1;
            if (reg_wr && reg_addr == 0) m_ier = reg_wdata & 8'h3f;
            if (reg_wr && reg_addr == 1) m_dma = reg_wdata[3];
        end
    end

    function automatic int exp_ident();
        bit line, tmo, eord, rxd, txl, mdm;
        int rc;
        rc   = rx_count;
        line = m_ier[2] && (m_ovr | m_par | m_frm | m_brk);
        tmo  = m_ier[4] && m_tmo != 0 && rc != 0 && (m_dma != 0 ? rc < 4 : rc <= 4);
        eord = m_ier[5] && m_eord != 0;
        rxd  = m_ier[0] && m_dma == 0 && rc > 4;
        txl  = m_ier[1] && tx_count <= (m_dma != 0 ? 4 : 8);
        mdm  = m_ier[3] && m_mod != 0;
        if (line) return 8'h06;
        if (tmo)  return 8'h0C;
        if (eord) return 8'h08;
        if (rxd)  return 8'h04;
        if (txl)  return 8'h02;
        if (mdm)  return 8'h00;
        return 8'h01;
    endfunction

    function automatic int exp_read(input int a);
        case (a)
            0: return m_ier;
            1: return exp_ident();
            2: return {(m_par | m_frm | m_brk), 2'b00, m_brk, m_frm, m_par, m_ovr, rx_count != 0};
            default: return m_mod;
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cycles++;
        if (!rst) begin
            check(cur_req, "irq",     irq,     exp_ident() != 8'h01);
            check(cur_req, "dma_req", dma_req, m_act != 0 && m_dma != 0);
            check("R12",   "rx_clr",  rx_clr,  reg_wr && reg_addr == 1 && reg_wdata[1]);
            if (reg_rd) check(cur_req, "rdata", reg_rdata, exp_read(reg_addr));
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
        reg_rd = 1; reg_addr = a;
        #1;
        check(req, "read", reg_rdata, exp);
        tick();
        reg_rd = 0;
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            rx_push = 1; rx_count = rx_count + 1'b1;
            tick();
            rx_push = 0;
        end
    endtask

    task automatic pop(input int n);
        for (int i = 0; i < n; i++) begin
            rx_pop = 1; rx_count = rx_count - 1'b1;
            tick();
            rx_pop = 0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    always @(negedge clk) begin
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 0;
        tick();
        // R1 reset state
        check("R1", "irq", irq, 0);
        check("R1", "dma_req", dma_req, 0);
        rd_chk(1, 8'h01, "R1");
        rd_chk(2, 8'h00, "R1");

        // R4 R5 R3 receive data and transmit level, non-DMA
        cur_req = "R4";
        wr(0, 8'h03);
        push(5);
        rd_chk(1, 8'h04, "R4");
        cur_req = "R3";
        tx_count = 8; tick();
        rd_chk(1, 8'h04, "R3");
        cur_req = "R5";
        pop(1);
        rd_chk(1, 8'h02, "R5");
        tx_count = 9; tick();
        rd_chk(1, 8'h01, "R5");

        // R9 line status and error source
        cur_req = "R9";
        wr(0, 8'h07);
        err_parity = 1; tick(); err_parity = 0;
        rd_chk(1, 8'h06, "R9");
        rd_chk(2, 8'h85, "R9");
        rd_chk(2, 8'h01, "R9");
        err_overrun = 1; tick(); err_overrun = 0;
        rd_chk(2, 8'h03, "R9");
        reg_rd = 1; reg_addr = 2; err_break = 1; tick(); reg_rd = 0; err_break = 0;
        rd_chk(2, 8'h91, "R9");

        // R10 R2 modem source
        cur_req = "R10";
        wr(0, 8'h08);
        modem_delta = 1; tick(); modem_delta = 0;
        rd_chk(1, 8'h00, "R2");
        check("R10", "irq", irq, 1);
        reg_rd = 1; reg_addr = 3; modem_delta = 1; tick(); reg_rd = 0; modem_delta = 0;
        rd_chk(3, 8'h01, "R10");
        rd_chk(1, 8'h01, "R10");

        // R12 FIFO clear
        cur_req = "R12";
        reg_wr = 1; reg_addr = 1; reg_wdata = 8'h02;
        #1 check("R12", "rx_clr", rx_clr, 1);
        tick(); reg_wr = 0;
        rx_count = 0; tick();

        // R11 R8 R6 R7 DMA mode
        cur_req = "R11";
        wr(1, 8'h08);
        wr(0, 8'h34);
        push(6);
        check("R11", "dma_req", dma_req, 1);
        pop(4);
        check("R11", "dma_req after burst", dma_req, 0);
        cur_req = "R8";
        for (int i = 0; i < 300 && !irq; i++) tick();
        rd_chk(1, 8'h0C, "R8");
        cur_req = "R6";
        idle(40);
        rd_chk(1, 8'h0C, "R8");
        pop(2);
        rd_chk(1, 8'h08, "R6");
        cur_req = "R7";
        wr(0, 8'h14);
        rd_chk(1, 8'h01, "R7");
        wr(0, 8'h34);
        rd_chk(1, 8'h01, "R7");
        cur_req = "R6";
        idle(300);
        rd_chk(1, 8'h01, "R6");
        push(1);
        idle(150);
        rd_chk(1, 8'h0C, "R8");
        pop(1);
        rd_chk(1, 8'h08, "R6");
        cur_req = "R7";
        wr(0, 8'h34);
        rd_chk(1, 8'h08, "R7");
        wr(0, 8'h14);
        wr(0, 8'h34);
        rd_chk(1, 8'h01, "R7");

        // R13 receive data suppressed in DMA mode
        cur_req = "R13";
        wr(0, 8'h01);
        push(5);
        rd_chk(1, 8'h01, "R13");
        check("R13", "dma_req", dma_req, 1);
        wr(1, 8'h0A);
        rx_count = 0; tick();
        check("R12", "dma_req after clear", dma_req, 0);
        idle(5);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule